// File: doc/BRIEF.md
# GPE and Reset Register Block

This block holds a bank of general-purpose event (GPE) status latches and their matching enable bits. It also holds a write-only platform reset trigger. Both are reached through a simple register bus with 8 byte lanes and little-endian ordering. An 8-byte-aligned address selects a word, and byte enables pick the lanes inside it. Lane `i` of a word at address `A` is byte `A+i`.

The GPE word sits at offset 0x28. Lanes 0..STS_BYTES-1 hold the status bytes. The next STS_BYTES lanes, starting at offset 0x2C, hold the enable bytes. Each byte lane is served by its own logic, so any mix of 1 to 8 bytes can be written in one access.

External event inputs set status bits. Software clears a status bit by writing 1 to it. The level output `gpe_irq` is high while any status bit has its enable bit set. This term feeds the system control interrupt.

The reset trigger sits at offset 0x30 and always reads as zero. A full 4-byte write to it with bit 0 set produces a one-cycle `rst_req` pulse. That pulse comes from a two-state machine:

- `TRIG_IDLE` goes to `TRIG_FIRE` on a qualifying write.
- `TRIG_FIRE` stays in `TRIG_FIRE` only if another qualifying write arrives in that cycle.
- Otherwise `TRIG_FIRE` returns to `TRIG_IDLE`.

`rst_req` is high exactly while the machine is in `TRIG_FIRE`.

Top module: `gpe_reset_block`

## Requirements
- R1: While `rst_n` is low, and after it rises, all status and enable bits read as zero, and `gpe_irq` and `rst_req` are low. This includes a reset applied in the middle of operation.
- R2: An event input bit that is high at a clock edge sets its status bit. The bit stays set after the input falls.
- R3: A write to 0x28 clears each status bit whose lane byte enable is set and whose data bit is 1. Status bits written with 0, and lanes without a byte enable, are unchanged.
- R4: A write to 0x28 stores the data byte into each enable lane (lanes STS_BYTES..2*STS_BYTES-1) whose byte enable is set. Other enable lanes keep their value.
- R5: `gpe_irq` is high exactly when some status bit and its enable bit are both set. It follows a register change from the next cycle on.
- R6: When an event input bit and a software clear of the same status bit arrive in the same cycle, the bit ends up set.
- R7: A read returns `rd_valid` high one cycle after the request. At 0x28, the data carries status in lanes 0..3 and enables in lanes 4..7. Lanes without a byte enable read as zero.
- R8: A read of the reset register at 0x30 returns zero, whatever was written to it before.
- R9: A write to 0x30 with byte enables exactly 0x0F and data bit 0 set raises `rst_req` for the single cycle after the write.
- R10: A write to 0x30 with data bit 0 clear, or with byte enables other than 0x0F, produces no `rst_req` pulse.
- R11: Writes to any other address change no state, and reads of any other address return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low device reset |
| evt_in | input | STS_BYTES*8 | Event inputs, one per status bit |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | 8-byte-aligned word address |
| req_be | input | 8 | Byte enables, lane i = byte address + i |
| req_wdata | input | 64 | Write data, little-endian lanes |
| rd_valid | output | 1 | Read data valid, one cycle after the read request |
| rd_data | output | 64 | Read data |
| gpe_irq | output | 1 | Level interrupt term: any enabled status bit set |
| rst_req | output | 1 | One-cycle platform reset request |

## Verification
The bench uses the default build: STS_BYTES = 4, an 8-bit address, GPE word at 0x28 and reset word at 0x30. At this size, every one of the 32 event bits can be walked through set, enable, interrupt and clear.

All 16 byte-enable patterns on the enable half can be applied and compared against a lane-by-lane model. The bench also covers:
- partial-lane reads;
- the event-against-clear collision;
- every qualifying and non-qualifying form of the reset write.

// File: rtl/gpe_pkg.sv
package gpe_pkg;

    localparam int LANES  = 8;
    localparam int DATA_W = LANES * 8;

    typedef enum logic {
        TRIG_IDLE = 1'b0,
        TRIG_FIRE = 1'b1
    } trig_state_e;

endpackage

// File: rtl/gpe_lane.sv
module gpe_lane (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] evt,
    input  logic       sts_wr,
    input  logic       en_wr,
    input  logic [7:0] sts_wdata,
    input  logic [7:0] en_wdata,
    output logic [7:0] sts_q,
    output logic [7:0] en_q
);

    logic [7:0] clr_mask;

    always_comb begin
        clr_mask = sts_wr ? sts_wdata : 8'h00;
    end

    // event set has priority over a software clear of the same bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= 8'h00;
            en_q  <= 8'h00;
        end else begin
            sts_q <= (sts_q & ~clr_mask) | evt;
            if (en_wr) begin
                en_q <= en_wdata;
            end
        end
    end

endmodule

// File: rtl/gpe_rst_trig.sv
module gpe_rst_trig
    import gpe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire_req,
    output logic pulse
);

    trig_state_e state_q;
    trig_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRIG_IDLE: state_d = fire_req ? TRIG_FIRE : TRIG_IDLE;
            TRIG_FIRE: state_d = fire_req ? TRIG_FIRE : TRIG_IDLE;
            default:   state_d = TRIG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TRIG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        pulse = (state_q == TRIG_FIRE);
    end

endmodule

// File: rtl/gpe_reset_block.sv
module gpe_reset_block
    import gpe_pkg::*;
#(
    parameter int          STS_BYTES = 4,
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  GPE_BASE  = 8'h28,
    parameter logic [7:0]  RST_BASE  = 8'h30
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [STS_BYTES*8-1:0] evt_in,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [7:0]             req_be,
    input  logic [63:0]            req_wdata,
    output logic                   rd_valid,
    output logic [63:0]            rd_data,
    output logic                   gpe_irq,
    output logic                   rst_req
);

    localparam int EVT_W = STS_BYTES * 8;

    logic [EVT_W-1:0]  sts_q;
    logic [EVT_W-1:0]  en_q;
    logic              hit_gpe;
    logic              hit_rst;
    logic              wr_gpe;
    logic              fire_req;
    logic [DATA_W-1:0] rd_next;

    always_comb begin
        hit_gpe  = (req_addr == ADDR_W'(GPE_BASE));
        hit_rst  = (req_addr == ADDR_W'(RST_BASE));
        wr_gpe   = req_valid && req_write && hit_gpe;
        fire_req = req_valid && req_write && hit_rst &&
                   (req_be == 8'h0F) && req_wdata[0];
    end

    for (genvar g = 0; g < STS_BYTES; g++) begin : g_lane
        gpe_lane u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt       (evt_in[g*8 +: 8]),
            .sts_wr    (wr_gpe && req_be[g]),
            .en_wr     (wr_gpe && req_be[STS_BYTES+g]),
            .sts_wdata (req_wdata[g*8 +: 8]),
            .en_wdata  (req_wdata[(STS_BYTES+g)*8 +: 8]),
            .sts_q     (sts_q[g*8 +: 8]),
            .en_q      (en_q[g*8 +: 8])
        );
    end

    for (genvar l = 0; l < LANES; l++) begin : g_rd
        if (l < STS_BYTES) begin : g_sts
            assign rd_next[l*8 +: 8] = (hit_gpe && req_be[l]) ? sts_q[l*8 +: 8] : 8'h00;
        end else if (l < 2*STS_BYTES) begin : g_en
            assign rd_next[l*8 +: 8] = (hit_gpe && req_be[l]) ? en_q[(l-STS_BYTES)*8 +: 8] : 8'h00;
        end else begin : g_zero
            assign rd_next[l*8 +: 8] = 8'h00;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= req_valid && !req_write;
            rd_data  <= (req_valid && !req_write) ? rd_next : '0;
        end
    end

    always_comb begin
        gpe_irq = |(sts_q & en_q);
    end

    gpe_rst_trig u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_req (fire_req),
        .pulse    (rst_req)
    );

endmodule

// File: rtl/gpe_reset_block_chk.sv
module gpe_reset_block_chk #(
    parameter int         STS_BYTES = 4,
    parameter int         ADDR_W    = 8,
    parameter logic [7:0] RST_BASE  = 8'h30
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [STS_BYTES*8-1:0] evt_in,
    input logic                   req_valid,
    input logic                   req_write,
    input logic [ADDR_W-1:0]      req_addr,
    input logic [7:0]             req_be,
    input logic [63:0]            req_wdata,
    input logic                   rd_valid,
    input logic [63:0]            rd_data,
    input logic                   gpe_irq,
    input logic                   rst_req,
    input logic [STS_BYTES*8-1:0] sts_q,
    input logic [STS_BYTES*8-1:0] en_q
);

    // R2 R6
    evt_sets_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_in) |=> ((sts_q & $past(evt_in)) == $past(evt_in)));

    // R5
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !gpe_irq);

    // R5
    irq_needs_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q == '0) |-> !gpe_irq);

    // R7
    rd_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && !req_write));

    // R8
    rst_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(req_addr == ADDR_W'(RST_BASE))) |-> (rd_data == '0));

    // R9 R10
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(req_valid && req_write && req_addr == ADDR_W'(RST_BASE) &&
                          req_be == 8'h0F && req_wdata[0]));

endmodule

bind gpe_reset_block gpe_reset_block_chk #(
    .STS_BYTES (STS_BYTES),
    .ADDR_W    (ADDR_W),
    .RST_BASE  (RST_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_in    (evt_in),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_be    (req_be),
    .req_wdata (req_wdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .gpe_irq   (gpe_irq),
    .rst_req   (rst_req),
    .sts_q     (sts_q),
    .en_q      (en_q)
);

// File: tb/gpe_reset_block_test.sv
module gpe_reset_block_test;

    localparam int CLK_PERIOD = 10;
    localparam int STS_BYTES  = 4;
    localparam int EVT_W      = STS_BYTES * 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [EVT_W-1:0] evt_in = '0;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic [7:0]       req_addr = '0;
    logic [7:0]       req_be = '0;
    logic [63:0]      req_wdata = '0;
    logic             rd_valid;
    logic [63:0]      rd_data;
    logic             gpe_irq;
    logic             rst_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic pulse_seen;
    logic [63:0] rdv;
    logic [31:0] sts_m;
    logic [31:0] en_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpe_reset_block uut (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_be(req_be), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .gpe_irq(gpe_irq), .rst_req(rst_req)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [63:0] d, input logic [7:0] be);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        pulse_seen = rst_req;
        req_valid = 1'b0; req_write = 1'b0; req_be = '0; req_wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [7:0] be, output logic [63:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = be;
        @(negedge clk);
        d = rd_data;
        chk("R7 rd_valid", {63'd0, rd_valid}, 64'd1);
        req_valid = 1'b0; req_be = '0;
    endtask

    task automatic pulse_evt(input logic [EVT_W-1:0] e);
        @(negedge clk);
        evt_in = e;
        @(negedge clk);
        evt_in = '0;
    endtask

    function automatic logic [63:0] lane_mask(input logic [7:0] be);
        logic [63:0] m = '0;
        for (int i = 0; i < 8; i++) if (be[i]) m[i*8 +: 8] = 8'hFF;
        return m;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 irq in reset", {63'd0, gpe_irq}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rst_req", {63'd0, rst_req}, 64'd0);
        bus_read(8'h28, 8'hFF, rdv);
        chk("R1 regs zero", rdv, 64'd0);

        // R2 R3 R5 walk every event bit
        for (int b = 0; b < EVT_W; b++) begin
            pulse_evt(EVT_W'(1) << b);
            @(negedge clk);
            bus_read(8'h28, 8'hFF, rdv);
            chk("R2 sticky status", rdv, 64'(32'(1) << b));
            chk("R5 irq off when disabled", {63'd0, gpe_irq}, 64'd0);
            bus_write(8'h28, 64'(32'(1) << b) << 32, 8'hF0);
            chk("R5 irq on when enabled", {63'd0, gpe_irq}, 64'd1);
            bus_write(8'h28, 64'(32'(1) << b), 8'h0F);
            chk("R3 clear by one", {63'd0, gpe_irq}, 64'd0);
            bus_read(8'h28, 8'h0F, rdv);
            chk("R3 status cleared", rdv, 64'd0);
            bus_write(8'h28, 64'd0, 8'hF0);
        end

        // R3 zero writes and lane selection
        pulse_evt('1);
        bus_write(8'h28, 64'd0, 8'h0F);
        bus_read(8'h28, 8'h0F, rdv);
        chk("R3 write zero keeps", rdv, 64'h0000_0000_FFFF_FFFF);
        bus_write(8'h28, 64'hFFFF_FFFF_FFFF_FFFF, 8'h05);
        bus_read(8'h28, 8'h0F, rdv);
        chk("R3 lane select", rdv, 64'h0000_0000_FF00_FF00);
        sts_m = 32'hFF00_FF00;

        // R4 R5 R7 sweep enable byte enables
        en_m = '0;
        for (int p = 0; p < 16; p++) begin
            logic [31:0] d = 32'h1F2E_3D4C ^ (32'h0101_0101 * p);
            bus_write(8'h28, {d, 32'hFFFF_FFFF}, {p[3:0], 4'h0});
            for (int i = 0; i < 4; i++) if (p[i]) en_m[i*8 +: 8] = d[i*8 +: 8];
            bus_read(8'h28, 8'hFF, rdv);
            chk("R4 enable lanes", rdv, {en_m, sts_m});
            chk("R5 irq model", {63'd0, gpe_irq}, {63'd0, |(sts_m & en_m)});
        end
        for (int q = 1; q < 256; q = q * 3 + 2) begin
            bus_read(8'h28, q[7:0], rdv);
            chk("R7 partial read", rdv, {en_m, sts_m} & lane_mask(q[7:0]));
        end

        // R6 event beats clear
        bus_write(8'h28, 64'h0000_0000_FFFF_FFFF, 8'h0F);
        @(negedge clk);
        evt_in = 32'h0000_0020;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h28;
        req_wdata = 64'h0000_0000_0000_0020; req_be = 8'h0F;
        @(negedge clk);
        evt_in = '0; req_valid = 1'b0; req_write = 1'b0; req_be = '0;
        bus_read(8'h28, 8'h0F, rdv);
        chk("R6 event wins", rdv, 64'h20);

        // R9 R10 reset trigger
        bus_write(8'h30, 64'h1, 8'h0F);
        chk("R9 pulse high", {63'd0, pulse_seen}, 64'd1);
        @(negedge clk);
        chk("R9 pulse one cycle", {63'd0, rst_req}, 64'd0);
        bus_write(8'h30, 64'hFFFF_FFFE, 8'h0F);
        chk("R10 bit0 clear", {63'd0, pulse_seen}, 64'd0);
        bus_write(8'h30, 64'h1, 8'hFF);
        chk("R10 wide access", {63'd0, pulse_seen}, 64'd0);
        bus_write(8'h30, 64'h1, 8'h01);
        chk("R10 narrow access", {63'd0, pulse_seen}, 64'd0);
        @(negedge clk);
        chk("R10 no late pulse", {63'd0, rst_req}, 64'd0);
        bus_read(8'h30, 8'h0F, rdv);
        chk("R8 reset reads zero", rdv, 64'd0);

        // R11 unmapped
        bus_write(8'h20, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);
        bus_write(8'h29, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF);
        bus_read(8'h28, 8'hFF, rdv);
        chk("R11 no state change", rdv, {en_m, 32'h20});
        bus_read(8'h20, 8'hFF, rdv);
        chk("R11 unmapped reads zero", rdv, 64'd0);

        // R1 mid-run reset
        bus_write(8'h28, 64'hFFFF_FFFF_0000_0000, 8'hF0);
        chk("R1 pre-reset irq", {63'd0, gpe_irq}, 64'd1);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 irq after reset", {63'd0, gpe_irq}, 64'd0);
        bus_read(8'h28, 8'hFF, rdv);
        chk("R1 regs after reset", rdv, 64'd0);

        finish_run();
    end

endmodule